// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port with Two-Address Register Interface

This block is a byte-wide serial port for a small processor's I/O bus. One register-select input picks between two addresses: address 0 holds status (read) and control (write), and address 1 holds the data register, which reads received bytes and takes bytes to transmit. The bus uses active-low, level-type read and write strobes. A write acts on the falling edge of its strobe. A read pops the receive buffer when its strobe rises. The read data path is combinational, so the processor samples `dout` while `n_rd` is low.

Serial timing comes from two clock-enable inputs that pulse at sixteen times the baud rate, one for each direction. Frames are 8N1: one start bit, eight data bits sent least significant bit first, and one stop bit. Received bytes pass through a 16-entry first-in first-out buffer before they reach the data register.

Flow control works in both directions:
- Receive side: `rts_n` tells the peer to stop sending once the buffer is nearly full.
- Transmit side: `cts_n` high stops the transmitter from starting a new frame. The processor sees the same back-pressure locally as the transmit-empty status bit.

Interrupts can be raised for received data and for an empty transmit register. A control-register code performs a master reset.

Top module: `acia_uart`

## Requirements
- R1: When reg_sel=0, a read returns status and a write (on the falling edge of n_wr) loads control. When reg_sel=1, a read returns the oldest buffered byte and a write loads the transmit holding register. A data read pops one byte when n_rd rises.
- R2: The status layout is: bit 0 receive-full, bit 1 transmit-empty, bits 2 and 3 (carrier detect and clear-to-send) always 0, bits 6:4 always 0, bit 7 interrupt pending. After rst_n the status reads 0x02 and txd is 1.
- R3: The transmitter sends the start bit (0), then eight data bits least significant bit first, then the stop bit (1). Each bit lasts 16 tx_ce pulses.
- R4: Transmit-empty (status bit 1) goes to 0 on a data write and returns to 1 when the byte moves into the shifter. A data write made while it is 0 is ignored.
- R5: No frame starts while the synchronized cts_n is high. A held byte starts after cts_n goes low.
- R6: The receiver detects a start bit as a falling edge of rxd at an rx_ce pulse and confirms it eight pulses later. It then samples eight data bits least significant bit first and the stop bit, each sixteen pulses apart.
- R7: A frame whose stop-bit sample is 0 is discarded.
- R8: Received bytes are buffered 16 deep and read back in arrival order. Receive-full (status bit 0) is 1 while the buffer is not empty. A byte that arrives when all 16 entries are used is dropped.
- R9: rts_n is 1 when fewer than 2 buffer entries are free or when the transmit-control field (control bits 6:5) is 10. Otherwise rts_n is 0.
- R10: irq and status bit 7 equal (control bit 7 AND receive-full) OR (control bits 6:5 == 01 AND transmit-empty).
- R11: A control write with bits 1:0 = 11 empties the buffer, abandons any frame in progress (txd returns to 1), empties the holding register and clears control bits 7 and 6:5. Any other control write loads bit 7 and bits 6:5.
- R12: Reading the data register while the buffer is empty returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_wr | input | 1 | Active-low write strobe |
| n_rd | input | 1 | Active-low read strobe |
| reg_sel | input | 1 | 0 = status/control, 1 = data |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| rx_ce | input | 1 | Receive enable pulse, 16x baud |
| tx_ce | input | 1 | Transmit enable pulse, 16x baud |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Peer ready to accept data, active low |
| rts_n | output | 1 | Request to peer to send, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest state to reach from the ports is a full receive buffer. A 17th frame arrives with no read in between, and the bench must also watch rts_n cross from 0 to 1 at exactly the second-to-last free entry. The stimulus sends seventeen back-to-back frames with no reads and samples rts_n after the 14th and 15th frames. It then drains the buffer through the scoreboard queue and checks that the 17th byte never appears.

A second hard case is a master reset that lands in the middle of a frame. The bench reaches it by releasing cts_n, writing a byte, waiting about three bit times, and then issuing the reset code.

// File: rtl/acia_uart_pkg.sv
package acia_uart_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  // transmit-control field codes (control bits 6:5)
  localparam logic [1:0] TC_TXIRQ   = 2'b01;
  localparam logic [1:0] TC_RTS_OFF = 2'b10;
  // control bits 1:0 code that resets the port
  localparam logic [1:0] CTRL_MRESET = 2'b11;
endpackage

// File: rtl/acia_rx_fifo.sv
// Receive buffer; DEPTH must be a power of two.
module acia_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [AW:0]   count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_pop  = pop && (count != '0);
  assign do_push = push && (count != (AW+1)'(DEPTH));
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/acia_uart_rx.sv
module acia_uart_rx
  import acia_uart_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16,
  localparam int TW = $clog2(OVS),
  localparam int BW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ce,
  input  logic          line,
  output logic          byte_valid,
  output logic [DW-1:0] byte_data
);
  localparam logic [TW-1:0] MID  = TW'(OVS/2 - 1);
  localparam logic [TW-1:0] LAST = TW'(OVS - 1);

  rx_state_t     st;
  logic [TW-1:0] tick;
  logic [BW-1:0] nbits;
  logic [DW-1:0] sh;
  logic          line_q;

  assign byte_data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; tick <= '0; nbits <= '0; sh <= '0;
      line_q <= 1'b1; byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (clr) begin
        st <= RX_IDLE; tick <= '0; nbits <= '0; line_q <= 1'b1;
      end else if (ce) begin
        line_q <= line;
        case (st)
          RX_IDLE: if (line_q && !line) begin
            st <= RX_START; tick <= '0;
          end
          RX_START: if (tick == MID) begin
            tick <= '0; nbits <= '0;
            st <= line ? RX_IDLE : RX_DATA;
          end else tick <= tick + 1'b1;
          RX_DATA: if (tick == LAST) begin
            tick  <= '0;
            sh    <= {line, sh[DW-1:1]};
            nbits <= nbits + 1'b1;
            if (nbits == BW'(DW - 1)) st <= RX_STOP;
          end else tick <= tick + 1'b1;
          RX_STOP: if (tick == LAST) begin
            tick <= '0; st <= RX_IDLE;
            if (line) byte_valid <= 1'b1;
          end else tick <= tick + 1'b1;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/acia_uart_tx.sv
module acia_uart_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16,
  localparam int TW = $clog2(OVS),
  localparam int FW = DW + 2,
  localparam int FB = $clog2(FW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ce,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          cts_ok,
  output logic          empty,
  output logic          busy,
  output logic          txd
);
  localparam logic [TW-1:0] LAST = TW'(OVS - 1);

  logic          hold_full;
  logic [DW-1:0] hold;
  logic [FW-1:0] sh;
  logic [FB-1:0] nbit;
  logic [TW-1:0] tick;

  assign empty = !hold_full;
  assign txd   = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0; hold <= '0; sh <= '1; nbit <= '0; tick <= '0; busy <= 1'b0;
    end else if (clr) begin
      hold_full <= 1'b0; sh <= '1; nbit <= '0; tick <= '0; busy <= 1'b0;
    end else begin
      if (wr && !hold_full) begin
        hold <= wdata; hold_full <= 1'b1;
      end
      if (!busy && hold_full && cts_ok) begin
        sh <= {1'b1, hold, 1'b0};
        busy <= 1'b1; hold_full <= 1'b0; tick <= '0; nbit <= '0;
      end else if (busy && ce) begin
        if (tick == LAST) begin
          tick <= '0;
          sh   <= {1'b1, sh[FW-1:1]};
          nbit <= nbit + 1'b1;
          if (nbit == FB'(FW - 1)) busy <= 1'b0;
        end else tick <= tick + 1'b1;
      end
    end
  end
endmodule

// File: rtl/acia_uart.sv
module acia_uart
  import acia_uart_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16,
  parameter int RTS_MARGIN = 2,
  localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          n_wr,
  input  logic          n_rd,
  input  logic          reg_sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic          rx_ce,
  input  logic          tx_ce,
  input  logic          rxd,
  output logic          txd,
  input  logic          cts_n,
  output logic          rts_n,
  output logic          irq
);
  logic          n_wr_q, n_rd_q, rd_sel_q;
  logic          rxd_m, rxd_s, cts_m, cts_s;
  logic [1:0]    tc;
  logic          rie;
  logic          wr_ev, data_wr, ctrl_wr, mreset, pop;
  logic          rx_valid, tdre, rdrf, tx_busy;
  logic [DW-1:0] rx_byte, head, status;
  logic [CW-1:0] fifo_count;
  logic          unused_din;

  assign unused_din = ^din[4:2];

  // strobe edges and input synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_wr_q <= 1'b1; n_rd_q <= 1'b1; rd_sel_q <= 1'b0;
      rxd_m <= 1'b1; rxd_s <= 1'b1; cts_m <= 1'b1; cts_s <= 1'b1;
    end else begin
      n_wr_q <= n_wr;
      n_rd_q <= n_rd;
      if (!n_rd) rd_sel_q <= reg_sel;
      rxd_m <= rxd;   rxd_s <= rxd_m;
      cts_m <= cts_n; cts_s <= cts_m;
    end
  end

  assign wr_ev   = n_wr_q && !n_wr;
  assign data_wr = wr_ev && reg_sel;
  assign ctrl_wr = wr_ev && !reg_sel;
  assign mreset  = ctrl_wr && (din[1:0] == CTRL_MRESET);
  assign pop     = !n_rd_q && n_rd && rd_sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc <= '0; rie <= 1'b0;
    end else if (mreset) begin
      tc <= '0; rie <= 1'b0;
    end else if (ctrl_wr) begin
      tc <= din[6:5]; rie <= din[7];
    end
  end

  acia_uart_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(mreset), .ce(rx_ce), .line(rxd_s),
    .byte_valid(rx_valid), .byte_data(rx_byte)
  );

  acia_rx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(mreset), .push(rx_valid), .push_data(rx_byte),
    .pop(pop), .head(head), .count(fifo_count)
  );

  acia_uart_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(mreset), .ce(tx_ce), .wr(data_wr), .wdata(din),
    .cts_ok(!cts_s), .empty(tdre), .busy(tx_busy), .txd(txd)
  );

  assign rdrf   = (fifo_count != '0);
  assign rts_n  = (tc == TC_RTS_OFF) || (fifo_count > CW'(FIFO_DEPTH - RTS_MARGIN));
  assign irq    = (rie && rdrf) || ((tc == TC_TXIRQ) && tdre);
  // bits 2,3 (carrier, clear-to-send) hardwired to 0
  assign status = DW'({irq, 3'b000, 1'b0, 1'b0, tdre, rdrf});
  assign dout   = reg_sel ? (rdrf ? head : '0) : status;
endmodule

// File: rtl/acia_uart_chk.sv
module acia_uart_chk #(
  parameter int DEPTH  = 16,
  parameter int MARGIN = 2,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fifo_count,
  input logic          rts_n,
  input logic          tx_busy,
  input logic          cts_s,
  input logic          tdre,
  input logic          data_wr,
  input logic          mreset,
  input logic          txd
);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  // R9
  rts_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count > CW'(DEPTH - MARGIN)) |-> rts_n);

  // R5
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(!cts_s));

  // R4
  tdre_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tdre) |-> $past(data_wr));

  // R11
  mreset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> (fifo_count == '0) && txd && tdre);
endmodule

bind acia_uart acia_uart_chk #(.DEPTH(FIFO_DEPTH), .MARGIN(RTS_MARGIN), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .rts_n(rts_n), .tx_busy(tx_busy),
  .cts_s(cts_s), .tdre(tdre), .data_wr(data_wr), .mreset(mreset), .txd(txd)
);

// File: tb/sim_acia_uart.sv
module sim_acia_uart;
  localparam int CE_DIV  = 4;
  localparam int BIT_CYC = 16 * CE_DIV;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, n_wr = 1'b1, n_rd = 1'b1, reg_sel = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       ce = 1'b0, rxd = 1'b1, cts_n = 1'b0;
  logic       txd, rts_n, irq;

  int checks = 0, bad = 0, tx_seen = 0;
  bit mon_en = 1'b0, done = 1'b0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  acia_uart u0 (
    .clk(clk), .rst_n(rst_n), .n_wr(n_wr), .n_rd(n_rd), .reg_sel(reg_sel),
    .din(din), .dout(dout), .rx_ce(ce), .tx_ce(ce), .rxd(rxd), .txd(txd),
    .cts_n(cts_n), .rts_n(rts_n), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // enable pulse generator
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      ce = (c == 0);
      c = (c + 1) % CE_DIV;
    end
  end

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; din = d; n_wr = 1'b0;
    @(negedge clk); n_wr = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; n_rd = 1'b0;
    @(negedge clk); d = dout; n_rd = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] b);
    logic [7:0] s;
    do bus_read(1'b0, s); while (!s[1]);
    tx_q.push_back(b);
    bus_write(1'b1, b);
  endtask

  task automatic send_line(input logic [7:0] b, input bit good_stop);
    @(negedge clk); rxd = 1'b0;
    repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    rxd = good_stop;
    repeat (BIT_CYC) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic expect_rx(input string req);
    logic [7:0] d;
    bus_read(1'b1, d);
    if (rx_q.size() == 0) check(req, d, 0);
    else check(req, d, rx_q.pop_front());
  endtask

  // transmit monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(negedge txd);
      if (mon_en) begin
        logic [7:0] b;
        repeat (BIT_CYC/2) @(negedge clk);
        check("R3 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT_CYC) @(negedge clk);
          b[i] = txd;
        end
        repeat (BIT_CYC) @(negedge clk);
        check("R3 stop bit", txd, 1);
        if (tx_q.size() == 0) check("R3 unexpected frame", b, 'h100);
        else check("R3 frame data", b, tx_q.pop_front());
        tx_seen++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    bus_read(1'b0, s);
    check("R2 reset status", s, 8'h02);
    check("R2 reset txd", txd, 1);
    check("R9 reset rts_n", rts_n, 0);
    check("R10 reset irq", irq, 0);

    // R3 several transmit patterns
    mon_en = 1'b1;
    send_tx(8'hA5); send_tx(8'h3C); send_tx(8'h00); send_tx(8'hFF);
    wait (tx_seen == 4);
    repeat (BIT_CYC) @(negedge clk);

    // R5 clear-to-send gating, R4 holding register behaviour
    cts_n = 1'b1;
    repeat (4) @(negedge clk);
    tx_q.push_back(8'h81);
    bus_write(1'b1, 8'h81);
    bus_read(1'b0, s);
    check("R4 tdre after write", s[1], 0);
    bus_write(1'b1, 8'h7E);
    repeat (3 * BIT_CYC) @(negedge clk);
    check("R5 txd held idle", txd, 1);
    check("R5 no frame while cts high", tx_seen, 4);
    cts_n = 1'b0;
    wait (tx_seen == 5);
    repeat (12 * BIT_CYC) @(negedge clk);
    check("R4 write while full ignored", tx_seen, 5);
    bus_read(1'b0, s);
    check("R4 tdre back to 1", s[1], 1);

    // R6 receive, R8 flag, R1 pop
    rx_q.push_back(8'h5A);
    send_line(8'h5A, 1'b1);
    bus_read(1'b0, s);
    check("R8 rdrf set", s[0], 1);
    expect_rx("R6 received byte");
    bus_read(1'b0, s);
    check("R1 pop clears rdrf", s[0], 0);

    // R12 read when empty
    bus_read(1'b1, s);
    check("R12 empty read data", s, 0);
    bus_read(1'b0, s);
    check("R12 status unchanged", s, 8'h02);

    // R7 bad stop bit dropped
    send_line(8'hC3, 1'b0);
    bus_read(1'b0, s);
    check("R7 bad frame dropped", s[0], 0);
    rx_q.push_back(8'h96);
    send_line(8'h96, 1'b1);
    expect_rx("R7 next good frame");

    // R8/R9 fill to overflow
    for (int i = 0; i < 17; i++) begin
      if (i < 16) rx_q.push_back(8'h10 + 8'(i));
      send_line(8'h10 + 8'(i), 1'b1);
      if (i == 13) check("R9 rts_n low with 2 free", rts_n, 0);
      if (i == 14) check("R9 rts_n high with 1 free", rts_n, 1);
    end
    for (int i = 0; i < 16; i++) expect_rx("R8 order");
    bus_read(1'b0, s);
    check("R8 overflow byte dropped", s[0], 0);
    check("R9 rts_n low after drain", rts_n, 0);

    // R10 interrupts, R9 control field
    bus_write(1'b0, 8'h80);
    check("R10 rie no data", irq, 0);
    rx_q.push_back(8'h33);
    send_line(8'h33, 1'b1);
    check("R10 rx irq", irq, 1);
    bus_read(1'b0, s);
    check("R10 status bit7", s[7], 1);
    expect_rx("R10 data");
    check("R10 irq cleared", irq, 0);
    bus_write(1'b0, 8'h20);
    check("R10 tx irq", irq, 1);
    bus_write(1'b0, 8'h40);
    check("R9 tc=10 rts_n", rts_n, 1);
    check("R10 tc=10 no irq", irq, 0);
    bus_write(1'b0, 8'h00);
    check("R9 tc=00 rts_n", rts_n, 0);

    // R11 master reset mid-frame
    send_line(8'h11, 1'b1);
    send_line(8'h22, 1'b1);
    mon_en = 1'b0;
    bus_write(1'b0, 8'hA0);
    bus_write(1'b1, 8'h55);
    repeat (3 * BIT_CYC) @(negedge clk);
    bus_write(1'b0, 8'h03);
    check("R11 txd idle", txd, 1);
    bus_read(1'b0, s);
    check("R11 status cleared", s, 8'h02);
    check("R11 irq cleared", irq, 0);
    repeat (12 * BIT_CYC) @(negedge clk);
    check("R11 line stays idle", txd, 1);
    mon_en = 1'b1;
    send_tx(8'h42);
    wait (tx_seen == 6);
    check("R11 queue drained", tx_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule